// File: doc/BRIEF.md
# Digit-Serial Montgomery Modular Multiplier

This block computes the Montgomery product A·B·2^-528 mod N for 528-bit operands. Each operand is handled as eleven 48-bit digits. A caller places A, B, the odd modulus N and the 48-bit constant N' = −N^-1 mod 2^48 on the inputs and raises `start` for one cycle. The block loads all four values at once and runs eleven outer passes, one for each digit of A. Each pass takes exactly eight clock cycles. In a pass, the current digit of A is multiplied by every digit of B and the products are added into a wide accumulator. The block then forms the reduction quotient from the lowest accumulator digit, adds the quotient times N, and shifts the accumulator down by one digit.

Four shared 48×48 digit multipliers do all the products. Each is assembled from six 24×16 partial products. The accumulator is updated through a 3:2 compressor followed by a carry-select adder made of 48-bit segments. The same adder is reused in one extra cycle after the last pass, to subtract N when the accumulated value is not already below N. A one-cycle `done` pulse then marks a valid `result`, which holds until the next job finishes.

Top module: `mont_mult`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block resets synchronously: `done` is 0 and `result` is all zeros.
- R2: With N odd, A < N, B < N and the correct N', `result` equals A·B·2^-528 mod N.
- R3: Every delivered `result` is strictly less than N.
- R4: A = 0 yields `result` = 0.
- R5: B = 1 yields `result` = A·2^-528 mod N.
- R6: The worst-case operands A = B = N−1 with N = 2^528−1 give the correct product. The internal accumulator never carries above bit 576.
- R7: `done` rises on the 89th rising edge after the edge that accepted `start` (11 passes × 8 cycles, plus 1 correction cycle). It stays high for exactly one cycle, and `result` keeps its value afterwards.
- R8: A `start` raised while a job is running, including its correction cycle, is ignored. The operands are not reloaded, and the running job's result and timing are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a multiplication; sampled only while idle |
| a_in | input | 528 | Multiplicand A, must be below N |
| b_in | input | 528 | Multiplier B, must be below N |
| n_in | input | 528 | Modulus N, must be odd |
| nprime_in | input | 48 | −N^-1 mod 2^48 |
| done | output | 1 | One-cycle pulse when `result` is valid |
| result | output | 528 | A·B·2^-528 mod N, held until the next completion |

## Verification
The checks on the cleared low digit, the accumulator headroom and the result bound rely on three input conditions:
- N is odd.
- Both A and B are below N.
- `nprime_in` really is the negated inverse of N modulo 2^48.

If any of these is false, the quotient no longer cancels the low digit and the bounds fail. The stimulus meets them in the following way. Every modulus is forced odd. Random operands are reduced modulo N before use. N' is derived in the bench by a Newton inversion of the low digit of N. The directed cases (A = 0, B = 1, A = B = N−1 with the all-ones modulus) stay inside the same limits.

// File: rtl/mont_pkg.sv
// Shared types for the Montgomery multiplier.
// Assumes: nothing beyond the encoding below being private to this block.
package mont_pkg;
    // Job control states of the top-level sequencer.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } mm_state_t;
endpackage

// File: rtl/mont_digit_mul.sv
// Combinational DW x DW unsigned digit multiplier.
// Tiles the product from (DW/SA) x (DW/SB) narrow partial products of SA x SB bits,
// each shifted to its weight and summed.
// Assumes: SA and SB divide DW exactly.
module mont_digit_mul #(
    parameter int DW = 48,
    parameter int SA = 24,
    parameter int SB = 16
) (
    input  logic [DW-1:0]   x,
    input  logic [DW-1:0]   y,
    output logic [2*DW-1:0] p
);
    localparam int NA = DW / SA;
    localparam int NB = DW / SB;
    localparam int PW = SA + SB;
    localparam int NP = NA * NB;

    logic [PW-1:0] pp [NP];

    // One narrow multiplier per (x slice, y slice) pair.
    for (genvar i = 0; i < NA; i++) begin : g_xs
        for (genvar j = 0; j < NB; j++) begin : g_ys
            assign pp[i*NB+j] = PW'(x[i*SA +: SA]) * PW'(y[j*SB +: SB]);
        end
    end

    // Weight and sum the partial products into the full digit product.
    always_comb begin
        p = '0;
        for (int i = 0; i < NA; i++) begin
            for (int j = 0; j < NB; j++) begin
                p = p + (((2*DW)'(pp[i*NB+j])) << (i*SA + j*SB));
            end
        end
    end
endmodule

// File: rtl/mont_csel_add.sv
// Segmented carry-select adder: NS segments of SW bits.
// Each segment precomputes its sum for carry-in 0 and 1. The carry rippling out of
// the segment below only chooses between them, so the critical path is one SW-bit
// add plus NS multiplexers.
// Assumes: operands are unsigned; cout is the carry out of the top segment.
module mont_csel_add #(
    parameter int SW = 48,
    parameter int NS = 13
) (
    input  logic [SW*NS-1:0] a,
    input  logic [SW*NS-1:0] b,
    input  logic             cin,
    output logic [SW*NS-1:0] sum,
    output logic             cout
);
    logic [SW:0] s0 [NS];
    logic [SW:0] s1 [NS];

    // Speculative segment sums for both possible carry-ins.
    for (genvar g = 0; g < NS; g++) begin : g_seg
        assign s0[g] = {1'b0, a[g*SW +: SW]} + {1'b0, b[g*SW +: SW]};
        assign s1[g] = {1'b0, a[g*SW +: SW]} + {1'b0, b[g*SW +: SW]} + (SW+1)'(1);
    end

    // Carry select chain across the segments.
    always_comb begin
        logic c;
        c = cin;
        for (int g = 0; g < NS; g++) begin
            sum[g*SW +: SW] = c ? s1[g][SW-1:0] : s0[g][SW-1:0];
            c               = c ? s1[g][SW]     : s0[g][SW];
        end
        cout = c;
    end
endmodule

// File: rtl/mont_mult.sv
// Digit-serial Montgomery multiplier: result = A*B*2^-(DW*ND) mod N.
// One outer pass per digit of A, each taking ITER cycles:
//   phases 0..NG-1   : acc += a_i * b_j, NM digits of B per cycle
//   phase  NG        : q = (acc digit 0 * N') mod 2^DW
//   phases NG+1..2NG : acc += q * n_j, NM digits of N per cycle
//   last phase       : acc >>= DW (the dropped digit is zero)
// One correction cycle then subtracts N if acc >= N.
// Assumes: N odd, A,B < N, nprime = -N^-1 mod 2^DW. start is ignored while busy.
module mont_mult
    import mont_pkg::*;
#(
    parameter int DW = 48,
    parameter int ND = 11,
    parameter int NM = 4,
    parameter int SA = 24,
    parameter int SB = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DW*ND-1:0] a_in,
    input  logic [DW*ND-1:0] b_in,
    input  logic [DW*ND-1:0] n_in,
    input  logic [DW-1:0]    nprime_in,
    output logic             done,
    output logic [DW*ND-1:0] result
);
    localparam int W        = DW * ND;
    localparam int NG       = (ND + NM - 1) / NM;
    localparam int ITER     = 2 * NG + 2;
    localparam int NSEG     = ND + 2;
    localparam int AW       = NSEG * DW;
    localparam int PH_W     = $clog2(ITER);
    localparam int IX_W     = $clog2(ND);

    mm_state_t         st;
    logic [PH_W-1:0]   ph;
    logic [IX_W-1:0]   idx;
    logic [W-1:0]      a_r, b_r, n_r;
    logic [DW-1:0]     np_r, q_r;
    logic [AW-1:0]     acc;

    logic              ph_mul_ab, ph_q, ph_mul_qn, ph_shift;
    int                slot_base;
    logic [DW-1:0]     mx [NM];
    logic [DW-1:0]     my [NM];
    logic [2*DW-1:0]   prod [NM];
    logic [AW-1:0]     lo_v, hi_v, cs_s, cs_c;
    logic [AW-1:0]     add_a, add_b, add_sum;
    logic              add_cin, add_cout;
    logic [W-1:0]      final_val;

    // Decode the phase counter into schedule slots and the digit group base.
    always_comb begin
        int p;
        p         = int'(ph);
        ph_mul_ab = (p < NG);
        ph_q      = (p == NG);
        ph_mul_qn = (p > NG) && (p <= 2 * NG);
        ph_shift  = (p == ITER - 1);
        if (p < NG)
            slot_base = p * NM;
        else if (p > NG && p <= 2 * NG)
            slot_base = (p - NG - 1) * NM;
        else
            slot_base = 0;
    end

    // Steer operands onto the shared digit multipliers for the current phase.
    always_comb begin
        for (int k = 0; k < NM; k++) begin
            int j;
            j     = slot_base + k;
            mx[k] = '0;
            my[k] = '0;
            if (ph_mul_ab) begin
                mx[k] = a_r[int'(idx)*DW +: DW];
                if (j < ND) my[k] = b_r[j*DW +: DW];
            end else if (ph_q) begin
                if (k == 0) begin
                    mx[k] = acc[DW-1:0];
                    my[k] = np_r;
                end
            end else if (ph_mul_qn) begin
                mx[k] = q_r;
                if (j < ND) my[k] = n_r[j*DW +: DW];
            end
        end
    end

    for (genvar k = 0; k < NM; k++) begin : g_mul
        mont_digit_mul #(.DW(DW), .SA(SA), .SB(SB)) u_mul (
            .x (mx[k]),
            .y (my[k]),
            .p (prod[k])
        );
    end

    // Place low and high product halves at their digit weights (no overlap within each vector).
    always_comb begin
        lo_v = '0;
        hi_v = '0;
        for (int k = 0; k < NM; k++) begin
            int j;
            j = slot_base + k;
            if (j < ND) begin
                lo_v[j*DW +: DW]     = prod[k][DW-1:0];
                hi_v[(j+1)*DW +: DW] = prod[k][2*DW-1:DW];
            end
        end
    end

    // 3:2 compression of accumulator and the two product vectors.
    always_comb begin
        cs_s = acc ^ lo_v ^ hi_v;
        cs_c = ((acc & lo_v) | (acc & hi_v) | (lo_v & hi_v)) << 1;
    end

    // Adder input select: accumulate during passes, acc - N during correction.
    always_comb begin
        if (st == ST_FIN) begin
            add_a   = acc;
            add_b   = ~{{(AW-W){1'b0}}, n_r};
            add_cin = 1'b1;
        end else begin
            add_a   = cs_s;
            add_b   = cs_c;
            add_cin = 1'b0;
        end
    end

    mont_csel_add #(.SW(DW), .NS(NSEG)) u_add (
        .a    (add_a),
        .b    (add_b),
        .cin  (add_cin),
        .sum  (add_sum),
        .cout (add_cout)
    );

    // Keep the difference only when no borrow occurred (acc >= N).
    always_comb begin
        final_val = add_cout ? add_sum[W-1:0] : acc[W-1:0];
    end

    // Sequencer: load, run ND passes of ITER phases, correct, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            ph     <= '0;
            idx    <= '0;
            a_r    <= '0;
            b_r    <= '0;
            n_r    <= '0;
            np_r   <= '0;
            q_r    <= '0;
            acc    <= '0;
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        a_r  <= a_in;
                        b_r  <= b_in;
                        n_r  <= n_in;
                        np_r <= nprime_in;
                        acc  <= '0;
                        ph   <= '0;
                        idx  <= '0;
                        st   <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (ph_mul_ab || ph_mul_qn) begin
                        acc <= add_sum;
                    end else if (ph_q) begin
                        q_r <= prod[0][DW-1:0];
                    end else begin
                        acc <= acc >> DW;
                        if (idx == IX_W'(ND - 1)) st <= ST_FIN;
                        else                      idx <= idx + 1'b1;
                    end
                    ph <= (ph == PH_W'(ITER - 1)) ? '0 : ph + 1'b1;
                end
                ST_FIN: begin
                    result <= final_val;
                    done   <= 1'b1;
                    st     <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mont_mult_chk.sv
// Property checker for mont_mult, attached by bind below.
// Assumes: inputs obey the block's contract (N odd, A,B < N, correct N').
module mont_mult_chk #(
    parameter int DW = 48,
    parameter int ND = 11,
    parameter int NM = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start,
    input logic                   done,
    input logic                   busy,
    input logic                   shift_ph,
    input logic [(ND+2)*DW-1:0]   acc,
    input logic [DW*ND-1:0]       a_r,
    input logic [DW*ND-1:0]       b_r,
    input logic [DW*ND-1:0]       n_r,
    input logic [DW*ND-1:0]       result
);
    localparam int NG       = (ND + NM - 1) / NM;
    localparam int ITER     = 2 * NG + 2;
    localparam int LAT      = ND * ITER + 1;
    localparam int AW       = (ND + 2) * DW;
    localparam int ACC_BITS = (ND + 1) * DW + 1;

    logic [15:0] since_go;

    // Count edges since the accepting start, for the latency window.
    always_ff @(posedge clk) begin
        if (!rst_n)             since_go <= '0;
        else if (!busy && start) since_go <= '0;
        else if (busy)          since_go <= since_go + 16'd1;
    end

    assert_low_digit_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_ph |-> (acc[DW-1:0] == '0));

    assert_result_below_n_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result < n_r));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        acc[AW-1:ACC_BITS] == '0);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (since_go == 16'(LAT)));

    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(a_r) && $stable(b_r) && $stable(n_r)));
endmodule

bind mont_mult mont_mult_chk #(.DW(DW), .ND(ND), .NM(NM)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .done     (done),
    .busy     (st != mont_pkg::ST_IDLE),
    .shift_ph (ph_shift && (st == mont_pkg::ST_RUN)),
    .acc      (acc),
    .a_r      (a_r),
    .b_r      (b_r),
    .n_r      (n_r),
    .result   (result)
);

// File: tb/sim_mont_mult.sv
// Self-checking bench for mont_mult: directed corners plus seeded random operands,
// compared against a bit-serial Montgomery reference computed here.
module sim_mont_mult;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 528;
    localparam int DW         = 48;
    localparam int LAT        = 89;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [W-1:0]  a_in = '0, b_in = '0, n_in = '0;
    logic [DW-1:0] np_in = '0;
    logic          done;
    logic [W-1:0]  result;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mont_mult u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .a_in      (a_in),
        .b_in      (b_in),
        .n_in      (n_in),
        .nprime_in (np_in),
        .done      (done),
        .result    (result)
    );

    // Bit-serial reference: A*B*2^-528 mod N.
    function automatic logic [W-1:0] ref_mont(input logic [W-1:0] a, b, n);
        logic [W+1:0] t;
        t = '0;
        for (int i = 0; i < W; i++) begin
            if (a[i]) t = t + {2'b00, b};
            if (t[0]) t = t + {2'b00, n};
            t = t >> 1;
        end
        if (t >= {2'b00, n}) t = t - {2'b00, n};
        return t[W-1:0];
    endfunction

    // -N^-1 mod 2^48 by Newton iteration on the low digit.
    function automatic logic [DW-1:0] calc_np(input logic [W-1:0] n);
        logic [DW-1:0] n0, inv;
        n0  = n[DW-1:0];
        inv = n0;
        for (int i = 0; i < 6; i++) inv = inv * (48'd2 - n0 * inv);
        return -inv;
    endfunction

    function automatic logic [W-1:0] rand_wide();
        logic [543:0] v;
        v = '0;
        for (int k = 0; k < 17; k++) v = {v[511:0], $urandom()};
        return v[W-1:0];
    endfunction

    task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One job: drive, wait for done, check value, bound, latency and pulse width.
    task automatic do_run(input logic [W-1:0] a, b, n, input bit poke, input string req);
        logic [W-1:0] exp;
        int  cnt;
        bit  got;
        exp = ref_mont(a, b, n);
        @(negedge clk);
        a_in = a; b_in = b; n_in = n; np_in = calc_np(n); start = 1'b1;
        cnt = 0; got = 1'b0;
        while (!got && cnt < 400) begin
            @(negedge clk);
            cnt++;
            if (cnt == 1) start = 1'b0;
            if (poke && cnt == 30) begin start = 1'b1; a_in = ~a; b_in = '0; n_in = n ^ 2; end
            if (poke && cnt == 31) start = 1'b0;
            if (done) got = 1'b1;
        end
        check(got, "R7 done seen", W'(got), W'(1));
        check(cnt - 1 == LAT, "R7 latency", W'(cnt - 1), W'(LAT));
        check(result == exp, req, result, exp);
        check(result < n, "R3 below N", result, n);
        @(negedge clk);
        check(!done && result == exp, "R7 one-cycle done, result held", {result[W-1:1], done}, {exp[W-1:1], 1'b0});
    endtask

    initial begin
        logic [W-1:0] n, a, b;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(done == 1'b0 && result == '0, "R1 reset", {result[W-1:1], done}, '0);
        rst_n = 1'b1;

        n = rand_wide() | (W'(1) << (W-1)) | W'(1);
        do_run('0, rand_wide() % n, n, 1'b0, "R4 A=0");
        a = rand_wide() % n;
        do_run(a, W'(1), n, 1'b0, "R5 B=1");
        do_run(n - 1, n - 1, n, 1'b0, "R2 A=B=N-1");
        do_run({W{1'b1}} - 1, {W{1'b1}} - 1, {W{1'b1}}, 1'b0, "R6 max operands");
        do_run(rand_wide() % n, rand_wide() % n, n, 1'b1, "R8 start ignored while busy");

        for (int r = 0; r < 8; r++) begin
            if (r == 4) n = (rand_wide() >> 200) | W'(1);
            else        n = rand_wide() | W'(1);
            a = rand_wide() % n;
            b = rand_wide() % n;
            do_run(a, b, n, 1'b0, "R2 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog R7: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule